// File: doc/BRIEF.md
# Banked RAM Memory Mapper

This block converts CPU addresses into physical RAM selections for a machine that has one base 64 KB page and up to eight extra 64 KB expansion pages. The CPU address space has four 16 KB windows, chosen by address bits 15..14. A single 8-bit configuration register sets the layout. Software writes it through an I/O write on the CPU data bus. The stored value picks one of five window arrangements and one expansion page.

For each access the block returns three things: the remapped window bits, which become the bank address bits 15..14; a 3-bit page number; and exactly one of two selects, one for base RAM and one for expansion RAM. Video fetches always go to the base page without any remapping. An external RAM-disable input can take a CPU access away from both RAM arrays, so that memory outside the block can respond. Address translation is combinational. Only the register is clocked.

Top module: `bank_mapper`

## Requirements
- R1: The register loads on a rising clock edge when all of these hold: `io_wr_n` is 0, `cpu_addr_hi[1]` (address bit 15) is 0, and `data_in[7:6]` is 2'b11. Address bit 14 has no effect on this decode. Field positions: mode = `data_in[2:0]`, page = `data_in[5:3]`.
- R2: A write with address bit 15 at 1, or with `data_in[7:6]` other than 2'b11, leaves the register unchanged. Data presented while `io_wr_n` is 1 also leaves it unchanged.
- R3: Mode 0 on a CPU cycle: every window maps to the base bank with the same number, so `map_addr_hi` equals `cpu_addr_hi` and `base_sel` is 1.
- R4: Mode 1: window 3 goes to expansion page p, bank 3. Windows 0 to 2 stay on base banks 0 to 2.
- R5: Mode 2: window n goes to expansion page p, bank n, for all four windows.
- R6: Mode 3: window 1 goes to base bank 3, window 3 goes to expansion page p bank 3, and windows 0 and 2 stay on base banks 0 and 2.
- R7: Modes 4 to 7: window 1 goes to expansion page p, bank `mode[1:0]`. Windows 0, 2 and 3 stay on base banks 0, 2 and 3.
- R8: On a video cycle (`cpu_cycle` = 0), `base_sel` is 1, `map_addr_hi` equals `cpu_addr_hi` and `page_sel` is 0, whatever the register holds and whatever `ext_ram_dis` is.
- R9: When `ext_ram_dis` is 1 on a CPU cycle, `base_sel` and `exp_sel` are both 0.
- R10: While `rst_n` is 0, mode and page are cleared at once, which gives the mode 0 layout. Release passes through a two-stage synchroniser.
- R11: `base_sel` and `exp_sel` are never both 1. `page_sel` carries the stored page while `exp_sel` is 1 and is 0 otherwise.
- R12: With parameter `SMALL_BUILD` = 1, the stored page is always 0 and `data_in[5:3]` is ignored.
- R13: The translation outputs follow the address and cycle inputs in the same cycle. A register write changes them only after the rising edge that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr_hi | input | 2 | CPU address bits 15..14 (window number) |
| io_wr_n | input | 1 | Active-low I/O write strobe |
| data_in | input | 8 | CPU data bus |
| cpu_cycle | input | 1 | 1 = CPU access, 0 = video access |
| ext_ram_dis | input | 1 | External RAM disable, acts on CPU cycles |
| map_addr_hi | output | 2 | Remapped address bits 15..14 (bank) |
| page_sel | output | 3 | Expansion page number |
| base_sel | output | 1 | Base RAM select |
| exp_sel | output | 1 | Expansion RAM select |

## Verification
Translation results are due in the same cycle as the address, cycle-flag and disable inputs. The bench therefore drives those inputs on a falling edge and samples one nanosecond later, with no clock edge in between. A configuration write is held for exactly one rising edge. Its effect is checked twice: once before that edge, where the old mapping must still hold, and once on the following falling edge, where the new mapping must be present. A reset assertion is checked one nanosecond after `rst_n` falls, with no clock edge between, because the clear is asynchronous. After reset is released, the bench waits out the two synchroniser stages before it writes again.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WIN_W  = 2;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned PAGE_W = 3;
  localparam int unsigned CFG_W  = MODE_W + PAGE_W;

  typedef logic [WIN_W-1:0] win_t;

  // page in the upper bits, mode in the lower bits
  typedef struct packed {
    logic [PAGE_W-1:0] page;
    logic [MODE_W-1:0] mode;
  } cfg_t;

  localparam win_t WIN_SECOND = win_t'(1);
  localparam win_t WIN_TOP    = win_t'(3);
  localparam win_t BANK_TOP   = win_t'(3);
endpackage

// File: rtl/bank_mapper_cfg.sv
module bank_mapper_cfg
  import bank_mapper_pkg::*;
#(
  parameter bit SMALL_BUILD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr_n,
  input  logic              addr_b15,
  input  logic [DATA_W-1:0] data_in,
  output cfg_t              cfg_q
);
  localparam int unsigned KEY_LSB = DATA_W - 2;

  logic              wr_hit;
  logic [PAGE_W-1:0] page_in;
  cfg_t              cfg_d;

  generate
    if (SMALL_BUILD) begin : g_small
      assign page_in = '0;
    end else begin : g_full
      assign page_in = data_in[MODE_W +: PAGE_W];
    end
  endgenerate

  always_comb begin
    wr_hit = !io_wr_n && !addr_b15 && (data_in[DATA_W-1:KEY_LSB] == 2'b11);
    cfg_d      = cfg_q;
    cfg_d.mode = data_in[MODE_W-1:0];
    cfg_d.page = page_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_hit) begin
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/bank_mapper_xlate.sv
module bank_mapper_xlate
  import bank_mapper_pkg::*;
(
  input  cfg_t              cfg,
  input  win_t              win,
  input  logic              cpu_cycle,
  input  logic              ext_ram_dis,
  output win_t              map_win,
  output logic [PAGE_W-1:0] page_sel,
  output logic              base_sel,
  output logic              exp_sel
);
  logic use_exp;
  logic blocked;
  win_t bank;

  always_comb begin
    use_exp = 1'b0;
    bank    = win;
    if (cpu_cycle) begin
      if (cfg.mode[MODE_W-1]) begin
        // single-window modes: second window takes bank b of page p
        if (win == WIN_SECOND) begin
          use_exp = 1'b1;
          bank    = cfg.mode[WIN_W-1:0];
        end
      end else begin
        case (cfg.mode[WIN_W-1:0])
          2'd0: use_exp = 1'b0;
          2'd1: use_exp = (win == WIN_TOP);
          2'd2: use_exp = 1'b1;
          2'd3: begin
            if (win == WIN_SECOND) begin
              bank = BANK_TOP;
            end else if (win == WIN_TOP) begin
              use_exp = 1'b1;
            end
          end
          default: use_exp = 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    blocked  = cpu_cycle && ext_ram_dis;
    base_sel = !use_exp && !blocked;
    exp_sel  = use_exp && !blocked;
    page_sel = exp_sel ? cfg.page : '0;
    map_win  = bank;
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter bit          SMALL_BUILD = 1'b0,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIN_W-1:0]  cpu_addr_hi,
  input  logic              io_wr_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cpu_cycle,
  input  logic              ext_ram_dis,
  output logic [WIN_W-1:0]  map_addr_hi,
  output logic [PAGE_W-1:0] page_sel,
  output logic              base_sel,
  output logic              exp_sel
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;
  cfg_t                  cfg_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe[RST_STAGES-1];

  bank_mapper_cfg #(
    .SMALL_BUILD (SMALL_BUILD)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .io_wr_n  (io_wr_n),
    .addr_b15 (cpu_addr_hi[WIN_W-1]),
    .data_in  (data_in),
    .cfg_q    (cfg_q)
  );

  bank_mapper_xlate u_xlate (
    .cfg         (cfg_q),
    .win         (cpu_addr_hi),
    .cpu_cycle   (cpu_cycle),
    .ext_ram_dis (ext_ram_dis),
    .map_win     (map_addr_hi),
    .page_sel    (page_sel),
    .base_sel    (base_sel),
    .exp_sel     (exp_sel)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk
  import bank_mapper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rst_core_n,
  input logic [WIN_W-1:0]  cpu_addr_hi,
  input logic              io_wr_n,
  input logic [DATA_W-1:0] data_in,
  input logic              cpu_cycle,
  input logic              ext_ram_dis,
  input logic [WIN_W-1:0]  map_addr_hi,
  input logic [PAGE_W-1:0] page_sel,
  input logic              base_sel,
  input logic              exp_sel,
  input logic [CFG_W-1:0]  cfg_bits
);
  logic good_wr;
  logic bad_wr;
  assign good_wr = !io_wr_n && !cpu_addr_hi[WIN_W-1] && (data_in[DATA_W-1:DATA_W-2] == 2'b11);
  assign bad_wr  = !io_wr_n && !good_wr;

  // R1
  good_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_core_n)
    good_wr |=> (cfg_bits[MODE_W-1:0] == $past(data_in[MODE_W-1:0])) &&
                ((cfg_bits[CFG_W-1:MODE_W] == $past(data_in[MODE_W +: PAGE_W])) ||
                 (cfg_bits[CFG_W-1:MODE_W] == '0)));

  // R2
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_core_n)
    bad_wr |=> $stable(cfg_bits));

  // R3
  mode0_identity_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_core_n)
    (cpu_cycle && !ext_ram_dis && cfg_bits[MODE_W-1:0] == '0) |-> (base_sel && map_addr_hi == cpu_addr_hi));

  // R8
  video_base_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_core_n)
    !cpu_cycle |-> (base_sel && !exp_sel && map_addr_hi == cpu_addr_hi && page_sel == '0));

  // R9
  ramdis_block_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_core_n)
    (cpu_cycle && ext_ram_dis) |-> (!base_sel && !exp_sel));

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_core_n)
    $onehot0({base_sel, exp_sel}) && (exp_sel || page_sel == '0));
endmodule

bind bank_mapper bank_mapper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_core_n  (rst_core_n),
  .cpu_addr_hi (cpu_addr_hi),
  .io_wr_n     (io_wr_n),
  .data_in     (data_in),
  .cpu_cycle   (cpu_cycle),
  .ext_ram_dis (ext_ram_dis),
  .map_addr_hi (map_addr_hi),
  .page_sel    (page_sel),
  .base_sel    (base_sel),
  .exp_sel     (exp_sel),
  .cfg_bits    (cfg_q)
);

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cpu_addr_hi = 2'd0;
  logic       io_wr_n = 1'b1;
  logic [7:0] data_in = 8'h00;
  logic       cpu_cycle = 1'b1;
  logic       ext_ram_dis = 1'b0;
  logic [1:0] map_addr_hi, sm_map;
  logic [2:0] page_sel, sm_page;
  logic       base_sel, exp_sel, sm_base, sm_exp;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  bank_mapper u_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .io_wr_n(io_wr_n),
    .data_in(data_in), .cpu_cycle(cpu_cycle), .ext_ram_dis(ext_ram_dis),
    .map_addr_hi(map_addr_hi), .page_sel(page_sel), .base_sel(base_sel), .exp_sel(exp_sel));

  bank_mapper #(.SMALL_BUILD(1'b1)) u_small (
    .clk(clk), .rst_n(rst_n), .cpu_addr_hi(cpu_addr_hi), .io_wr_n(io_wr_n),
    .data_in(data_in), .cpu_cycle(cpu_cycle), .ext_ram_dis(ext_ram_dis),
    .map_addr_hi(sm_map), .page_sel(sm_page), .base_sel(sm_base), .exp_sel(sm_exp));

  // vector: {cfg byte, window, expected bank, expected expansion flag}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {8'hC0, 2'd0, 2'd0, 1'b0},  // R3
    {8'hC0, 2'd3, 2'd3, 1'b0},  // R3
    {8'hC9, 2'd3, 2'd3, 1'b1},  // R4 page 1
    {8'hC9, 2'd2, 2'd2, 1'b0},  // R4
    {8'hD2, 2'd0, 2'd0, 1'b1},  // R5 page 2
    {8'hD2, 2'd1, 2'd1, 1'b1},  // R5
    {8'hD2, 2'd3, 2'd3, 1'b1},  // R5
    {8'hDB, 2'd1, 2'd3, 1'b0},  // R6 page 3
    {8'hDB, 2'd3, 2'd3, 1'b1},  // R6
    {8'hDB, 2'd0, 2'd0, 1'b0},  // R6
    {8'hDB, 2'd2, 2'd2, 1'b0},  // R6
    {8'hE6, 2'd1, 2'd2, 1'b1},  // R7 page 4 bank 2
    {8'hE6, 2'd0, 2'd0, 1'b0},  // R7
    {8'hE6, 2'd3, 2'd3, 1'b0},  // R7
    {8'hFC, 2'd1, 2'd0, 1'b1},  // R7 page 7 bank 0
    {8'hFF, 2'd1, 2'd3, 1'b1},  // R7 page 7 bank 3
    {8'hC1, 2'd3, 2'd3, 1'b1}   // R4 page 0
  };

  function automatic logic [7:0] pack(logic ex, logic bs, logic [2:0] pg, logic [1:0] mp);
    return {1'b0, ex, bs, pg, mp};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] hi, logic [7:0] val);
    @(negedge clk);
    cpu_addr_hi = hi;
    data_in = val;
    io_wr_n = 1'b0;
    @(negedge clk);
    io_wr_n = 1'b1;
  endtask

  task automatic look(logic [1:0] win, logic cpu, logic dis);
    @(negedge clk);
    cpu_addr_hi = win;
    cpu_cycle = cpu;
    ext_ram_dis = dis;
    #1;
  endtask

  function automatic logic [7:0] dut_out();
    return pack(exp_sel, base_sel, page_sel, map_addr_hi);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: reset state
    #1;
    look(2'd3, 1'b1, 1'b0);
    check("R10 reset layout", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd3));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] c;
      logic [1:0] w, b;
      logic ex;
      string req;
      {c, w, b, ex} = VEC[i];
      if (c[2]) req = "R7";
      else if (c[1:0] == 2'd0) req = "R3";
      else if (c[1:0] == 2'd1) req = "R4";
      else if (c[1:0] == 2'd2) req = "R5";
      else req = "R6";
      cfg_write(2'b01, c);
      look(w, 1'b1, 1'b0);
      check(req, dut_out(), pack(ex, !ex, ex ? c[5:3] : 3'd0, b));
    end

    // R13: combinational follow of the window without a clock edge
    cfg_write(2'b01, 8'hC9);
    @(negedge clk);
    cpu_addr_hi = 2'd3;
    #1 check("R13 same-cycle window 3", dut_out(), pack(1'b1, 1'b0, 3'd1, 2'd3));
    cpu_addr_hi = 2'd1;
    #1 check("R13 same-cycle window 1", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd1));

    // R1 / R13: write with bit14=0 lands only after the edge
    cfg_write(2'b01, 8'hC0);
    @(negedge clk);
    cpu_addr_hi = 2'b00;
    cpu_cycle = 1'b1;
    data_in = 8'hD2;
    io_wr_n = 1'b0;
    #1 check("R13 before edge old map", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd0));
    @(negedge clk);
    io_wr_n = 1'b1;
    #1 check("R1 bit14=0 write loaded", dut_out(), pack(1'b1, 1'b0, 3'd2, 2'd0));

    // R2: ignored writes (mode 2 page 2 stays)
    cfg_write(2'b10, 8'hC0);
    look(2'd0, 1'b1, 1'b0);
    check("R2 bit15=1 ignored", dut_out(), pack(1'b1, 1'b0, 3'd2, 2'd0));
    cfg_write(2'b01, 8'h80);
    look(2'd0, 1'b1, 1'b0);
    check("R2 key bits 10 ignored", dut_out(), pack(1'b1, 1'b0, 3'd2, 2'd0));
    cfg_write(2'b01, 8'h40);
    look(2'd0, 1'b1, 1'b0);
    check("R2 key bits 01 ignored", dut_out(), pack(1'b1, 1'b0, 3'd2, 2'd0));
    @(negedge clk);
    data_in = 8'hC0;
    cpu_addr_hi = 2'b01;
    repeat (2) @(negedge clk);
    look(2'd0, 1'b1, 1'b0);
    check("R2 no strobe ignored", dut_out(), pack(1'b1, 1'b0, 3'd2, 2'd0));

    // R8: video cycles in mode 2
    look(2'd2, 1'b0, 1'b0);
    check("R8 video unmapped", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd2));
    look(2'd1, 1'b0, 1'b1);
    check("R8 video ignores disable", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd1));

    // R9: disable on CPU cycles, expansion and base windows
    look(2'd3, 1'b1, 1'b1);
    check("R9 disable blocks expansion", {6'd0, exp_sel, base_sel}, 8'h00);
    cfg_write(2'b01, 8'hC0);
    look(2'd0, 1'b1, 1'b1);
    check("R9 disable blocks base", {6'd0, exp_sel, base_sel}, 8'h00);

    // R11: page only with expansion select
    cfg_write(2'b01, 8'hF9);
    look(2'd0, 1'b1, 1'b0);
    check("R11 page zero on base", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd0));

    // R12: small build ignores page bits
    cfg_write(2'b01, 8'hFA);
    look(2'd2, 1'b1, 1'b0);
    check("R12 small build page", pack(sm_exp, sm_base, sm_page, sm_map), pack(1'b1, 1'b0, 3'd0, 2'd2));
    check("R12 full build page", dut_out(), pack(1'b1, 1'b0, 3'd7, 2'd2));

    // R10: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R10 async clear", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd2));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    look(2'd3, 1'b1, 1'b0);
    check("R10 after release", dut_out(), pack(1'b0, 1'b1, 3'd0, 2'd3));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule